// File: doc/BRIEF.md
# Show-Ahead FIFO Drain Port

This block sits between a slow producer and a memory-mapped bus. The producer pushes 36-bit words into an internal show-ahead FIFO at its own pace, typically one word every several hundred nanoseconds. A bus master, usually a DMA engine, drains the FIFO by issuing reads. Each read that the block samples removes one entry. The lower 32 bits of that entry come back on the read data bus exactly one clock later. There are no wait states, so a back-to-back burst returns one word on every clock.

A level interrupt tells software that enough data has built up to be worth moving. It is high while the fill level is at or above a fixed threshold, which defaults to 480 of the 512 entries, and an enable input can hold it off. Two sticky flags record misuse. One is set by a read issued while the FIFO is empty. The other is set by a push issued while the FIFO is full. Both stay set until reset.

Top module: `fifo_drain_slave`

## Requirements
- R1: After reset, level_o is 0 and irq_o, readvalid_o, ovf_o and unf_o are all low.
- R2: readvalid_o is high in a cycle exactly when cs_i and rd_i were both high at the previous rising edge. The read latency is one clock and there are no wait states.
- R3: During a cycle with readvalid_o high and a non-empty FIFO, readdata_o equals bits 31:0 of the oldest entry. Entries come back in push order, one per clock during a back-to-back burst.
- R4: level_o counts the entries held. It goes up by one for each accepted push and down by one for each read strobe that finds the FIFO non-empty.
- R5: A word pushed into an empty FIFO can be returned by a read strobe issued in the very next cycle. The head word is visible without a prior fetch.
- R6: With irq_en_i high, irq_o is high in a cycle exactly when level_o is at or above IRQ_LEVEL (default 480).
- R7: While irq_en_i was low at the previous edge, irq_o is low, whatever the level.
- R8: A read strobe that finds the FIFO empty leaves level_o at 0 and sets unf_o. unf_o then stays high until reset.
- R9: A push while level_o equals DEPTH (default 512) is dropped, even if a read strobe pops in the same cycle. It sets ovf_o, which then stays high until reset.
- R10: An accepted push and a non-empty pop at the same edge leave level_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Producer push request |
| push_data_i | input | 36 | Word to push |
| cs_i | input | 1 | Bus chip select |
| rd_i | input | 1 | Bus read request |
| irq_en_i | input | 1 | Interrupt enable |
| readdata_o | output | 32 | Bits 31:0 of the head entry |
| readvalid_o | output | 1 | Read data valid, one clock after the strobe |
| level_o | output | 10 | Number of entries held |
| irq_o | output | 1 | Level interrupt |
| ovf_o | output | 1 | Sticky push-when-full flag |
| unf_o | output | 1 | Sticky read-when-empty flag |

## Verification
The assertions assume a single clock domain. Each push and each read strobe is taken as a one-cycle event sampled at the rising edge. The read data is trusted only when the FIFO held an entry at the popping edge. Stimulus changes only on falling edges and comes from a seeded random mix of pushes, reads and enable changes. Directed runs around it fill the FIFO past the threshold and into overflow, then drain it in one unbroken burst and keep reading into underflow. This reaches each boundary the properties talk about without ever presenting an input mid-cycle.

// File: rtl/fds_pkg.sv
package fds_pkg;
  localparam int unsigned FDS_DEPTH     = 512;
  localparam int unsigned FDS_WORD_W    = 36;
  localparam int unsigned FDS_BUS_W     = 32;
  localparam int unsigned FDS_IRQ_LEVEL = 480;

  typedef struct packed {
    logic push_ok;
    logic pop_ok;
  } fds_xfer_t;
endpackage

// File: rtl/fds_ctrl.sv
module fds_ctrl #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned LW = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 push_i,
  input  logic                 pop_q,
  output fds_pkg::fds_xfer_t   xfer,
  output logic [PW-1:0]        wptr,
  output logic [PW-1:0]        rd_addr,
  output logic [LW-1:0]        level,
  output logic [LW-1:0]        level_nxt,
  output logic                 ovf,
  output logic                 unf
);
  logic [PW-1:0] rptr;
  logic          full;
  logic          empty;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);

  always_comb begin
    xfer.pop_ok  = pop_q & ~empty;
    xfer.push_ok = push_i & ~full;
    rd_addr      = xfer.pop_ok ? rptr + PW'(1) : rptr;
    level_nxt    = level + LW'(xfer.push_ok) - LW'(xfer.pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      if (xfer.push_ok) wptr <= wptr + PW'(1);
      rptr  <= rd_addr;
      level <= level_nxt;
      if (push_i && full) ovf <= 1'b1;
      if (pop_q && empty) unf <= 1'b1;
    end
  end
endmodule

// File: rtl/fds_store.sv
module fds_store #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned WORD_W = 36,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PW-1:0]     raddr,
  output logic [WORD_W-1:0] head
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] ram_q;
  logic [WORD_W-1:0] byp_data;
  logic              byp_sel;

  // Plain synchronous-read array so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ram_q <= mem[raddr];
  end

  // A word written to the address being fetched is forwarded.
  always_ff @(posedge clk) begin
    byp_sel  <= we && (waddr == raddr);
    byp_data <= wdata;
  end

  assign head = byp_sel ? byp_data : ram_q;
endmodule

// File: rtl/fds_irq.sv
module fds_irq #(
  parameter int unsigned LW        = 10,
  parameter int unsigned IRQ_LEVEL = 480
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] level_nxt,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= en && (level_nxt >= LW'(IRQ_LEVEL));
  end
endmodule

// File: rtl/fifo_drain_slave.sv
module fifo_drain_slave #(
  parameter int unsigned DEPTH     = fds_pkg::FDS_DEPTH,
  parameter int unsigned WORD_W    = fds_pkg::FDS_WORD_W,
  parameter int unsigned BUS_W     = fds_pkg::FDS_BUS_W,
  parameter int unsigned IRQ_LEVEL = fds_pkg::FDS_IRQ_LEVEL,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned LW = PW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              irq_en_i,
  output logic [BUS_W-1:0]  readdata_o,
  output logic              readvalid_o,
  output logic [LW-1:0]     level_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              unf_o
);
  fds_pkg::fds_xfer_t xfer;
  logic              pop_q;
  logic [PW-1:0]     wptr;
  logic [PW-1:0]     rd_addr;
  logic [LW-1:0]     level_nxt;
  logic [WORD_W-1:0] head;

  // Registered strobe: the pop takes effect one edge after the request.
  always_ff @(posedge clk) begin
    if (rst) pop_q <= 1'b0;
    else     pop_q <= cs_i & rd_i;
  end

  fds_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_q(pop_q), .xfer(xfer),
    .wptr(wptr), .rd_addr(rd_addr), .level(level_o), .level_nxt(level_nxt),
    .ovf(ovf_o), .unf(unf_o)
  );

  fds_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .we(xfer.push_ok), .waddr(wptr), .wdata(push_data_i),
    .raddr(rd_addr), .head(head)
  );

  fds_irq #(.LW(LW), .IRQ_LEVEL(IRQ_LEVEL)) u_irq (
    .clk(clk), .rst(rst), .en(irq_en_i), .level_nxt(level_nxt), .irq(irq_o)
  );

  generate
    if (BUS_W < WORD_W) begin : g_narrow
      assign readdata_o = head[BUS_W-1:0];
    end else begin : g_wide
      assign readdata_o = BUS_W'(head);
    end
  endgenerate

  assign readvalid_o = pop_q;
endmodule

// File: rtl/fds_chk.sv
module fds_chk #(
  parameter int unsigned DEPTH     = 512,
  parameter int unsigned IRQ_LEVEL = 480,
  parameter int unsigned LW        = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          push_i,
  input logic          cs_i,
  input logic          rd_i,
  input logic          irq_en_i,
  input logic          readvalid_o,
  input logic [LW-1:0] level_o,
  input logic          irq_o,
  input logic          ovf_o,
  input logic          unf_o
);
  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_i && rd_i) |=> readvalid_o);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(cs_i && rd_i) |=> !readvalid_o);
  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level_o <= LW'(DEPTH));
  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (level_o >= LW'(IRQ_LEVEL)));
  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en_i |=> !irq_o);
  // R8
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unf_o |=> unf_o);
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (readvalid_o && level_o == '0 && !push_i) |=> (level_o == '0 && unf_o));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  // R9
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && level_o == LW'(DEPTH) && !readvalid_o) |=> (level_o == LW'(DEPTH) && ovf_o));
endmodule

bind fifo_drain_slave fds_chk #(.DEPTH(DEPTH), .IRQ_LEVEL(IRQ_LEVEL), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .push_i(push_i), .cs_i(cs_i), .rd_i(rd_i),
  .irq_en_i(irq_en_i), .readvalid_o(readvalid_o), .level_o(level_o),
  .irq_o(irq_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/fifo_drain_slave_tb.sv
`timescale 1ns/1ps
module fifo_drain_slave_tb;
  localparam int DEPTH = 512;
  localparam int TH    = 480;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_i = 1'b0;
  logic [35:0] push_data_i = '0;
  logic        cs_i = 1'b0;
  logic        rd_i = 1'b0;
  logic        irq_en_i = 1'b0;
  logic [31:0] readdata_o;
  logic        readvalid_o;
  logic [9:0]  level_o;
  logic        irq_o;
  logic        ovf_o;
  logic        unf_o;

  always #2 clk = ~clk;

  fifo_drain_slave u_dut (
    .clk(clk), .rst(rst), .push_i(push_i), .push_data_i(push_data_i),
    .cs_i(cs_i), .rd_i(rd_i), .irq_en_i(irq_en_i), .readdata_o(readdata_o),
    .readvalid_o(readvalid_o), .level_o(level_o), .irq_o(irq_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [35:0] q[$];
  bit m_popq = 0, m_irq = 0, m_ovf = 0, m_unf = 0;
  string data_tag  = "R3";
  string level_tag = "R4";
  string irq_tag   = "R6";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_irq(input bit en, input int lvl);
    return en && (lvl >= TH);
  endfunction

  task automatic compare();
    chk(readvalid_o == m_popq, "R2", readvalid_o, m_popq);
    chk(level_o == q.size(), level_tag, level_o, q.size());
    chk(irq_o == m_irq, irq_tag, irq_o, m_irq);
    chk(ovf_o == m_ovf, "R9", ovf_o, m_ovf);
    chk(unf_o == m_unf, "R8", unf_o, m_unf);
    if (m_popq && q.size() > 0)
      chk(readdata_o == q[0][31:0], data_tag, readdata_o, q[0][31:0]);
  endtask

  // Check state from the last edge, then drive and model the next edge.
  task automatic step(input bit p, input logic [35:0] d, input bit c, input bit r, input bit e);
    int sz;
    @(negedge clk);
    compare();
    push_i = p; push_data_i = d; cs_i = c; rd_i = r; irq_en_i = e;
    sz = q.size();
    if (m_popq && sz == 0) m_unf = 1;
    if (p && sz == DEPTH) m_ovf = 1;
    if (m_popq && sz > 0) void'(q.pop_front());
    if (p && sz < DEPTH) q.push_back(d);
    m_popq = c && r;
    m_irq  = exp_irq(e, q.size());
  endtask

  function automatic logic [35:0] rnd_word();
    logic [35:0] w;
    w[31:0]  = $urandom;
    w[35:32] = 4'($urandom);
    return w;
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(level_o == 0 && !irq_o && !readvalid_o && !ovf_o && !unf_o, "R1",
        {level_o, irq_o, readvalid_o, ovf_o, unf_o}, 0);

    // R5: push into empty, strobe on the next cycle
    data_tag = "R5";
    step(1, 36'hA_1234_5678, 0, 0, 1);
    step(0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 1);
    data_tag = "R3";

    // R10: push and pop on the same edge
    step(1, 36'h1_0000_0001, 0, 0, 1);
    step(1, 36'h2_0000_0002, 1, 1, 1);
    level_tag = "R10";
    step(1, 36'h3_0000_0003, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    level_tag = "R4";
    step(0, 0, 1, 1, 1);
    step(0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 1);

    // Fill past threshold (R6) into overflow (R9)
    for (int i = 0; i < DEPTH + 3; i++) step(1, rnd_word(), 0, 0, 1);
    // R9: push at full alongside a pop is still dropped
    step(1, 36'hF_FFFF_FFFF, 1, 1, 1);
    step(1, 36'hE_EEEE_EEEE, 0, 0, 1);
    // R7: masked while above threshold
    irq_tag = "R7";
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0);
    irq_tag = "R6";
    step(0, 0, 0, 0, 1);

    // R3 back-to-back burst drain, then R8 underflow
    for (int i = 0; i < DEPTH + 4; i++) step(0, 0, 1, 1, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1);

    // Seeded random mix
    for (int i = 0; i < 4000; i++) begin
      bit p, c, r, e;
      p = ($urandom % 100) < 55;
      c = ($urandom % 100) < 60;
      r = ($urandom % 100) < 80;
      e = ($urandom % 100) < 85;
      irq_tag = e ? "R6" : "R7";
      step(p, rnd_word(), c, r, e);
    end
    step(0, 0, 0, 0, 1);
    @(negedge clk);
    compare();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule